// File: doc/BRIEF.md
# Dual-Axis Encoder Position Compare

This block tracks two quadrature-encoder axes and raises a hardware compare output for each of them without any software in the loop. Every axis decodes its A/B pair into a 32-bit position count. Each axis also owns a compare unit that holds an upper and a lower trip point and a step value. Whenever the watched position arrives on a trip point, the compare output flips, and both trip points move one step further in the direction the axis is travelling. The result is a train of evenly spaced output edges, or a window that follows the motion.

A routing bit in each compare unit chooses which count that unit watches. The count can be the unit's own axis or axis 0. Once a higher unit watches axis 0, the output pin of axis 0 carries the OR of its own compare state and every compare state routed onto it. The higher unit's own pin still shows only its own state. Software programs the units through a one-cycle synchronous write strobe that carries a channel number, a register code and a data word.

Top module: `enc_cmp_pair`

## Requirements
- R1: The decoder counts on every edge of A and B. Taking {A,B}, the steps 00→10→11→01→00 each add one, and the reverse steps each subtract one. The new count shows on `pos_o` three clocks after the input change.
- R2: A step in which A and B change together gives a one-clock pulse on `quad_err_o` for that axis and leaves the count unchanged.
- R3: On a clock where the watched count has just moved to a value equal to the upper or lower trip point, the unit's compare state flips on the next clock.
- R4: On every such flip, both trip points move by the step value: upward for a count that rose, downward for one that fell. With no motion and no write, the trip points hold.
- R5: A write with register code 3 sets the compare state to data bit 0 on the next clock.
- R6: Writes with code 0 (upper trip point), code 1 (lower trip point) or code 2 (step value) take effect on the next clock and never flip the compare state by themselves.
- R7: A write with code 4 sets the routing bit from data bit 0. With the bit set, the unit compares against axis 0's count; with it clear, against its own axis.
- R8: Pin 0 is the OR of unit 0's state and the state of every higher unit whose routing bit is set. A higher unit's pin shows only its own state.
- R9: With every routing bit clear, motion on one axis leaves the other axis's pin and count unchanged.
- R10: When a code-3 write lands on the same clock as a trip-point match, the written value wins. The trip points still advance.
- R11: After reset, the counts, compare states, routing bits, trip points and error pulses are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_a_i | input | NUM_CH | Encoder A phase, one bit per axis (asynchronous) |
| enc_b_i | input | NUM_CH | Encoder B phase, one bit per axis (asynchronous) |
| wr_en_i | input | 1 | Register write strobe |
| wr_ch_i | input | CH_W | Target axis of the write |
| wr_reg_i | input | 3 | Register code: 0 upper, 1 lower, 2 step, 3 force state, 4 routing |
| wr_data_i | input | POS_W | Write data |
| cmp_pin_o | output | NUM_CH | Compare output pins after merging |
| pos_o | output | NUM_CH*POS_W | Position counts, axis 0 in the low bits |
| quad_err_o | output | NUM_CH | One-clock pulse on an illegal quadrature step |

## Verification
A match and a state-forcing write can fall in the same clock. The bench aligns them by moving the encoder and then holding off exactly the three clocks the synchronizer and decoder take. It then presents a code-3 write on the clock where the compare unit sees the count strobe. It judges the outcome in two ways. First, the pin must show the written value. Second, the next trip point must have moved by the step value, which shows when a later move flips the pin on the advanced position and not on the old one.

// File: rtl/enc_cmp_pkg.sv
package enc_cmp_pkg;

    // Register codes on wr_reg_i
    typedef enum logic [2:0] {
        REG_TRIP_HI = 3'd0,
        REG_TRIP_LO = 3'd1,
        REG_STEP    = 3'd2,
        REG_FORCE   = 3'd3,
        REG_ROUTE   = 3'd4
    } reg_code_e;

    localparam int REG_CODE_W = 3;

endpackage

// File: rtl/quad_track.sv
module quad_track #(
    parameter int POS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             qa_i,
    input  logic             qb_i,
    output logic [POS_W-1:0] pos_o,
    output logic             step_o,
    output logic             up_o,
    output logic             err_o
);

    typedef struct packed {
        logic [1:0]       sync1;
        logic [1:0]       sync2;
        logic [1:0]       prev;
        logic [POS_W-1:0] pos;
        logic             step;
        logic             up;
        logic             err;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d       = trk_q;
        trk_d.sync1 = {qa_i, qb_i};
        trk_d.sync2 = trk_q.sync1;
        trk_d.prev  = trk_q.sync2;
        trk_d.step  = 1'b0;
        trk_d.err   = 1'b0;
        case ({trk_q.prev, trk_q.sync2})
            4'b00_10, 4'b10_11, 4'b11_01, 4'b01_00: begin
                trk_d.pos  = trk_q.pos + POS_W'(1);
                trk_d.step = 1'b1;
                trk_d.up   = 1'b1;
            end
            4'b10_00, 4'b11_10, 4'b01_11, 4'b00_01: begin
                trk_d.pos  = trk_q.pos - POS_W'(1);
                trk_d.step = 1'b1;
                trk_d.up   = 1'b0;
            end
            4'b00_11, 4'b11_00, 4'b10_01, 4'b01_10: begin
                trk_d.err  = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign pos_o  = trk_q.pos;
    assign step_o = trk_q.step;
    assign up_o   = trk_q.up;
    assign err_o  = trk_q.err;

    AST_MOVE_HAS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_q.pos != $past(trk_q.pos)) |-> trk_q.step); // R1

    AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        trk_q.step |-> ((trk_q.pos == $past(trk_q.pos) + POS_W'(1)) ||
                        (trk_q.pos == $past(trk_q.pos) - POS_W'(1)))); // R1

    AST_ERR_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        trk_q.err |-> $stable(trk_q.pos)); // R2

endmodule

// File: rtl/cmp_unit.sv
module cmp_unit
    import enc_cmp_pkg::*;
#(
    parameter int POS_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic [REG_CODE_W-1:0] wr_reg_i,
    input  logic [POS_W-1:0]      wr_data_i,
    input  logic [POS_W-1:0]      pos_i,
    input  logic                  step_i,
    input  logic                  up_i,
    output logic                  state_o,
    output logic                  route_o
);

    typedef struct packed {
        logic [POS_W-1:0] trip_hi;
        logic [POS_W-1:0] trip_lo;
        logic [POS_W-1:0] stride;
        logic             state;
        logic             route;
    } cu_t;

    cu_t cu_d, cu_q;
    logic hit;
    logic force_we;

    assign hit      = step_i && ((pos_i == cu_q.trip_hi) || (pos_i == cu_q.trip_lo));
    assign force_we = wr_en_i && (wr_reg_i == REG_FORCE);

    always_comb begin
        cu_d = cu_q;
        if (hit) begin
            cu_d.state = ~cu_q.state;
            if (up_i) begin
                cu_d.trip_hi = cu_q.trip_hi + cu_q.stride;
                cu_d.trip_lo = cu_q.trip_lo + cu_q.stride;
            end else begin
                cu_d.trip_hi = cu_q.trip_hi - cu_q.stride;
                cu_d.trip_lo = cu_q.trip_lo - cu_q.stride;
            end
        end
        if (wr_en_i) begin
            case (wr_reg_i)
                REG_TRIP_HI: cu_d.trip_hi = wr_data_i;
                REG_TRIP_LO: cu_d.trip_lo = wr_data_i;
                REG_STEP:    cu_d.stride  = wr_data_i;
                REG_FORCE:   cu_d.state   = wr_data_i[0];
                REG_ROUTE:   cu_d.route   = wr_data_i[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cu_q <= '0;
        else        cu_q <= cu_d;
    end

    assign state_o = cu_q.state;
    assign route_o = cu_q.route;

    AST_FORCE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(force_we) |-> (state_o == $past(wr_data_i[0]))); // R10

    AST_QUIET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(step_i) && !$past(force_we)) |-> $stable(state_o)); // R6

    AST_TRIPS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(step_i) && !$past(wr_en_i)) |->
            ($stable(cu_q.trip_hi) && $stable(cu_q.trip_lo))); // R4

endmodule

// File: rtl/enc_cmp_pair.sv
module enc_cmp_pair
    import enc_cmp_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int POS_W  = 32,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH-1:0]       enc_a_i,
    input  logic [NUM_CH-1:0]       enc_b_i,
    input  logic                    wr_en_i,
    input  logic [CH_W-1:0]         wr_ch_i,
    input  logic [REG_CODE_W-1:0]   wr_reg_i,
    input  logic [POS_W-1:0]        wr_data_i,
    output logic [NUM_CH-1:0]       cmp_pin_o,
    output logic [NUM_CH*POS_W-1:0] pos_o,
    output logic [NUM_CH-1:0]       quad_err_o
);

    logic [POS_W-1:0]  pos_w [NUM_CH];
    logic [NUM_CH-1:0] step_w;
    logic [NUM_CH-1:0] up_w;
    logic [NUM_CH-1:0] state_w;
    logic [NUM_CH-1:0] route_w;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_axis
        logic [POS_W-1:0] watch_pos;
        logic             watch_step;
        logic             watch_up;
        logic             ch_we;

        quad_track #(.POS_W(POS_W)) trk_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .qa_i   (enc_a_i[c]),
            .qb_i   (enc_b_i[c]),
            .pos_o  (pos_w[c]),
            .step_o (step_w[c]),
            .up_o   (up_w[c]),
            .err_o  (quad_err_o[c])
        );

        assign watch_pos  = route_w[c] ? pos_w[0]  : pos_w[c];
        assign watch_step = route_w[c] ? step_w[0] : step_w[c];
        assign watch_up   = route_w[c] ? up_w[0]   : up_w[c];
        assign ch_we      = wr_en_i && (wr_ch_i == CH_W'(c));

        cmp_unit #(.POS_W(POS_W)) cmp_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en_i   (ch_we),
            .wr_reg_i  (wr_reg_i),
            .wr_data_i (wr_data_i),
            .pos_i     (watch_pos),
            .step_i    (watch_step),
            .up_i      (watch_up),
            .state_o   (state_w[c]),
            .route_o   (route_w[c])
        );

        assign pos_o[c*POS_W +: POS_W] = pos_w[c];
    end

    always_comb begin
        cmp_pin_o = state_w;
        for (int c = 1; c < NUM_CH; c++) begin
            if (route_w[c]) cmp_pin_o[0] = cmp_pin_o[0] | state_w[c];
        end
    end

endmodule

// File: tb/enc_cmp_pair_tb_top.sv
`timescale 1ns/1ps
module enc_cmp_pair_tb_top;

    localparam int NUM_CH = 2;
    localparam int POS_W  = 32;
    localparam int LIMIT  = 150000;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [NUM_CH-1:0]       enc_a_i = '0;
    logic [NUM_CH-1:0]       enc_b_i = '0;
    logic                    wr_en_i = 1'b0;
    logic [0:0]              wr_ch_i = '0;
    logic [2:0]              wr_reg_i = '0;
    logic [POS_W-1:0]        wr_data_i = '0;
    logic [NUM_CH-1:0]       cmp_pin_o;
    logic [NUM_CH*POS_W-1:0] pos_o;
    logic [NUM_CH-1:0]       quad_err_o;

    always #2.5 clk = ~clk;

    enc_cmp_pair #(.NUM_CH(NUM_CH), .POS_W(POS_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .enc_a_i(enc_a_i), .enc_b_i(enc_b_i),
        .wr_en_i(wr_en_i), .wr_ch_i(wr_ch_i), .wr_reg_i(wr_reg_i),
        .wr_data_i(wr_data_i), .cmp_pin_o(cmp_pin_o), .pos_o(pos_o),
        .quad_err_o(quad_err_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    int err_cnt1 = 0;
    int cyc = 0;
    bit done = 0;
    int idx [NUM_CH] = '{0, 0};

    // table: direction (+1/-1), expected axis-0 count, expected pin 0
    localparam int TB_DIR [13] = '{ 1, 1, 1, 1, 1, 1, 1, -1, -1, -1, -1, -1, -1};
    localparam int TB_POS [13] = '{ 1, 2, 3, 4, 5, 6, 7,  6,  5,  4,  3,  2,  1};
    localparam int TB_PIN [13] = '{ 0, 0, 1, 1, 1, 1, 0,  0,  1,  1,  1,  1,  0};

    always @(negedge clk) if (rst_n && quad_err_o[1]) err_cnt1++;

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > LIMIT) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: act cycles=%0d exp below %0d", cyc, LIMIT);
            finish_run();
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: act=%0d exp=%0d", req, $signed(act), $signed(exp));
        end
    endtask

    function automatic logic [1:0] gray(int i);
        case (i)
            0: return 2'b00;
            1: return 2'b10;
            2: return 2'b11;
            default: return 2'b01;
        endcase
    endfunction

    task automatic drive_enc(int ch, int dir);
        idx[ch] = (idx[ch] + dir + 4) % 4;
        {enc_a_i[ch], enc_b_i[ch]} = gray(idx[ch]);
    endtask

    task automatic move(int ch, int dir);
        @(negedge clk);
        drive_enc(ch, dir);
        repeat (6) @(negedge clk);
    endtask

    task automatic wr(int ch, int code, int data);
        @(negedge clk);
        wr_en_i = 1'b1; wr_ch_i = 1'(ch); wr_reg_i = 3'(code); wr_data_i = data;
        @(negedge clk);
        wr_en_i = 1'b0;
        @(negedge clk);
    endtask

    // encoder step with a write placed on the clock the compare unit sees the strobe
    task automatic move_with_write(int ch, int dir, int wch, int code, int data);
        @(negedge clk);
        drive_enc(ch, dir);
        repeat (3) @(posedge clk);
        @(negedge clk);
        wr_en_i = 1'b1; wr_ch_i = 1'(wch); wr_reg_i = 3'(code); wr_data_i = data;
        @(negedge clk);
        wr_en_i = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [31:0] pos_of(int ch);
        return pos_o[ch*POS_W +: POS_W];
    endfunction

    initial begin
        repeat (4) @(negedge clk);
        // R11 reset state
        check("R11 pos0", pos_of(0), 0);
        check("R11 pos1", pos_of(1), 0);
        check("R11 pins", 32'(cmp_pin_o), 0);
        check("R11 err", 32'(quad_err_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // axis 0 window: upper 3, lower -3, step 4
        wr(0, 0, 3);
        wr(0, 1, -3);
        wr(0, 2, 4);
        check("R6 trip writes keep pin", 32'(cmp_pin_o[0]), 0);

        for (int i = 0; i < 13; i++) begin
            move(0, TB_DIR[i]);
            check($sformatf("R1 count step %0d", i), pos_of(0), TB_POS[i]);
            check($sformatf("R3 R4 pin0 step %0d", i), 32'(cmp_pin_o[0]), TB_PIN[i]);
        end

        // R9 axis 1 untouched by axis 0 motion
        check("R9 pin1", 32'(cmp_pin_o[1]), 0);
        check("R9 pos1", pos_of(1), 0);

        // R6 write a trip point equal to the current count: no flip
        wr(0, 0, 1);
        check("R6 no flip on trip write", 32'(cmp_pin_o[0]), 0);
        wr(0, 0, 100);
        wr(0, 1, -100);

        // R5 force state
        wr(0, 3, 1);
        check("R5 force high", 32'(cmp_pin_o[0]), 1);
        wr(0, 3, 0);
        check("R5 force low", 32'(cmp_pin_o[0]), 0);

        // R7 R8 axis 1 watches axis 0
        wr(1, 4, 1);
        wr(1, 0, 3);
        wr(1, 1, -50);
        wr(1, 2, 0);
        move(0, 1);
        check("R7 no hit at 2", 32'(cmp_pin_o[1]), 0);
        move(0, 1);
        check("R7 routed hit pin1", 32'(cmp_pin_o[1]), 1);
        check("R8 pin0 is OR", 32'(cmp_pin_o[0]), 1);
        check("R7 own axis1 unmoved", pos_of(1), 0);
        wr(1, 3, 0);
        check("R8 pin0 follows own state", 32'(cmp_pin_o[0]), 0);

        // R2 illegal step on axis 1
        @(negedge clk);
        {enc_a_i[1], enc_b_i[1]} = 2'b11;
        idx[1] = 2;
        repeat (6) @(negedge clk);
        check("R2 err pulse count", err_cnt1, 1);
        check("R2 count held", pos_of(1), 0);
        move(1, 1);
        check("R1 axis1 counts on", pos_of(1), 1);

        // R10 force write and match on one clock; axis 0 at 3
        wr(0, 0, 4);
        wr(0, 2, 2);
        move_with_write(0, 1, 0, 3, 0);
        check("R10 write wins", 32'(cmp_pin_o[0]), 0);
        move(0, 1);
        check("R10 no flip at 5", 32'(cmp_pin_o[0]), 0);
        move(0, 1);
        check("R10 R4 advanced trip at 6", 32'(cmp_pin_o[0]), 1);

        finish_run();
    end

endmodule